// File: doc/BRIEF.md
# Ring Stop with Bounce Delivery

This block is the node attachment point on a one-way ring made of register stages. In every cycle it takes the slot arriving from the upstream stage and fills the register that feeds the downstream stage. That register is this stop's own ring latch, so a flit moves exactly one stop per cycle. A flit addressed to this node is taken off the ring into a small local delivery FIFO. Local traffic from an injection port enters the ring only when the outgoing slot would otherwise be empty.

Flits already on the ring always win over local injection. A flit that reaches its home stop while the delivery FIFO is full is not stalled. It leaves on the outgoing slot with its bounce count raised by one and comes back on a later lap. Because of this, two flits from the same sender can reach the local node in the opposite order to the one in which they were sent.

Each flit has a valid bit, a destination ID, a source ID, a bounce count and a payload.

Top module: `ring_stop`

## Requirements
- R1: After reset, `dn_vld` and `ej_vld` are 0 and `inj_rdy` is 1 while the incoming slot is empty.
- R2: An incoming flit whose destination differs from `LOCAL_ID` appears on the `dn_*` outputs one cycle later. Its destination, source, bounce count and payload are unchanged.
- R3: Whenever an incoming flit is forwarded rather than delivered, `inj_rdy` is 0 in that cycle. No injected flit enters the ring in that cycle; the outgoing slot carries the forwarded flit.
- R4: An injection accepted (`inj_vld` and `inj_rdy` both 1) appears on `dn_*` one cycle later. It has valid 1, the given destination and payload, source `LOCAL_ID`, and bounce count 0.
- R5: An incoming flit with destination `LOCAL_ID` is written into the delivery FIFO when the FIFO holds fewer than `EJ_DEPTH` entries. From the next cycle it is visible on `ej_vld`/`ej_src`/`ej_data` once it reaches the head, and it is not forwarded.
- R6: In a cycle where an incoming flit is delivered, `inj_rdy` is 1. A pending injection takes the freed outgoing slot.
- R7: When an incoming flit has destination `LOCAL_ID` and the FIFO holds `EJ_DEPTH` entries, it is forwarded on `dn_*` one cycle later with its bounce count plus one. This applies even if the FIFO is popped in that same cycle.
- R8: The delivery FIFO hands out entries in the order they were written. `ej_vld` is 1 exactly when it is non-empty, and the head is removed at a clock edge where `ej_vld` and `ej_rdy` are both 1.
- R9: The bounce count saturates: a bounced flit that arrives with the all-ones count leaves with the all-ones count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_vld | input | 1 | Incoming ring slot occupied |
| up_dst | input | ID_W | Incoming flit destination |
| up_src | input | ID_W | Incoming flit source |
| up_bnc | input | BNC_W | Incoming flit bounce count |
| up_data | input | DATA_W | Incoming flit payload |
| dn_vld | output | 1 | Outgoing ring slot occupied |
| dn_dst | output | ID_W | Outgoing flit destination |
| dn_src | output | ID_W | Outgoing flit source |
| dn_bnc | output | BNC_W | Outgoing flit bounce count |
| dn_data | output | DATA_W | Outgoing flit payload |
| inj_vld | input | 1 | Local flit waiting to enter |
| inj_rdy | output | 1 | Outgoing slot free for injection |
| inj_dst | input | ID_W | Destination of local flit |
| inj_data | input | DATA_W | Payload of local flit |
| ej_vld | output | 1 | Delivery FIFO non-empty |
| ej_rdy | input | 1 | Local consumer takes head |
| ej_src | output | ID_W | Source of head flit |
| ej_data | output | DATA_W | Payload of head flit |

## Verification
The properties assume the upstream stage never presents a flit with an undefined destination while `up_vld` is high. They also assume the local side holds `inj_dst` and `inj_data` steady for the cycle in which it raises `inj_vld`. The bench drives all inputs on the falling edge and returns `up_vld` to 0 between scenarios, so each property sees one well-defined slot per cycle. It fills the FIFO to exactly `EJ_DEPTH` before sending further home-bound flits, so that the full and not-full cases are reached on purpose rather than by chance.

// File: rtl/ring_stop.sv
module ring_stop #(
  parameter int ID_W     = 4,
  parameter int DATA_W   = 16,
  parameter int BNC_W    = 4,
  parameter int EJ_DEPTH = 4,
  parameter int LOCAL_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_vld,
  input  logic [ID_W-1:0]   up_dst,
  input  logic [ID_W-1:0]   up_src,
  input  logic [BNC_W-1:0]  up_bnc,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_vld,
  output logic [ID_W-1:0]   dn_dst,
  output logic [ID_W-1:0]   dn_src,
  output logic [BNC_W-1:0]  dn_bnc,
  output logic [DATA_W-1:0] dn_data,
  input  logic              inj_vld,
  output logic              inj_rdy,
  input  logic [ID_W-1:0]   inj_dst,
  input  logic [DATA_W-1:0] inj_data,
  output logic              ej_vld,
  input  logic              ej_rdy,
  output logic [ID_W-1:0]   ej_src,
  output logic [DATA_W-1:0] ej_data
);
  localparam int PW = (EJ_DEPTH > 1) ? $clog2(EJ_DEPTH) : 1;
  localparam int CW = $clog2(EJ_DEPTH + 1);
  localparam logic [ID_W-1:0] ME = ID_W'(LOCAL_ID);
  localparam logic [CW-1:0] FULL_CNT = CW'(EJ_DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(EJ_DEPTH - 1);

  logic [ID_W-1:0]   src_q [EJ_DEPTH];
  logic [DATA_W-1:0] dat_q [EJ_DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt;

  logic hit, full, push, pass, pop, inj_go;
  logic [BNC_W-1:0] bnc_up;

  assign hit     = up_vld && (up_dst == ME);
  assign full    = (cnt == FULL_CNT);
  assign push    = hit && !full;
  assign pass    = up_vld && !push;
  assign inj_rdy = !pass;
  assign inj_go  = inj_vld && !pass;
  assign ej_vld  = (cnt != '0);
  assign pop     = ej_vld && ej_rdy;
  assign ej_src  = src_q[rd_ptr];
  assign ej_data = dat_q[rd_ptr];
  assign bnc_up  = (&up_bnc) ? up_bnc : up_bnc + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_vld  <= 1'b0;
      dn_dst  <= '0;
      dn_src  <= '0;
      dn_bnc  <= '0;
      dn_data <= '0;
    end else if (pass) begin
      dn_vld  <= 1'b1;
      dn_dst  <= up_dst;
      dn_src  <= up_src;
      dn_bnc  <= hit ? bnc_up : up_bnc;
      dn_data <= up_data;
    end else if (inj_go) begin
      dn_vld  <= 1'b1;
      dn_dst  <= inj_dst;
      dn_src  <= ME;
      dn_bnc  <= '0;
      dn_data <= inj_data;
    end else begin
      dn_vld  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      src_q[wr_ptr] <= up_src;
      dat_q[wr_ptr] <= up_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_vld && up_dst != ME) |=> (dn_vld && dn_dst == $past(up_dst) &&
      dn_src == $past(up_src) && dn_bnc == $past(up_bnc) && dn_data == $past(up_data)));

  assert_ring_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_vld && up_dst != ME) |-> !inj_rdy);

  assert_inject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_vld && inj_rdy) |=> (dn_vld && dn_src == ME && dn_bnc == '0 &&
      dn_data == $past(inj_data)));

  assert_deliver_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cnt < FULL_CNT) |=> ej_vld);

  assert_free_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cnt < FULL_CNT) |-> inj_rdy);

  assert_bounce_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cnt == FULL_CNT) |=> (dn_vld && dn_dst == ME &&
      dn_data == $past(up_data) && dn_bnc != '0));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);
endmodule

// File: tb/sim_ring_stop.sv
module sim_ring_stop;
  localparam int ID_W = 4, DATA_W = 16, BNC_W = 4, DEPTH = 2, ME = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic up_vld = 1'b0;
  logic [ID_W-1:0] up_dst = '0, up_src = '0;
  logic [BNC_W-1:0] up_bnc = '0;
  logic [DATA_W-1:0] up_data = '0;
  logic dn_vld, inj_rdy, ej_vld;
  logic [ID_W-1:0] dn_dst, dn_src, ej_src;
  logic [BNC_W-1:0] dn_bnc;
  logic [DATA_W-1:0] dn_data, ej_data;
  logic inj_vld = 1'b0, ej_rdy = 1'b0;
  logic [ID_W-1:0] inj_dst = '0;
  logic [DATA_W-1:0] inj_data = '0;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  ring_stop #(.ID_W(ID_W), .DATA_W(DATA_W), .BNC_W(BNC_W), .EJ_DEPTH(DEPTH), .LOCAL_ID(ME)) u0 (
    .clk(clk), .rst_n(rst_n),
    .up_vld(up_vld), .up_dst(up_dst), .up_src(up_src), .up_bnc(up_bnc), .up_data(up_data),
    .dn_vld(dn_vld), .dn_dst(dn_dst), .dn_src(dn_src), .dn_bnc(dn_bnc), .dn_data(dn_data),
    .inj_vld(inj_vld), .inj_rdy(inj_rdy), .inj_dst(inj_dst), .inj_data(inj_data),
    .ej_vld(ej_vld), .ej_rdy(ej_rdy), .ej_src(ej_src), .ej_data(ej_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_up(input logic v, input int dst, input int src, input int bnc, input int dat);
    @(negedge clk);
    up_vld = v; up_dst = ID_W'(dst); up_src = ID_W'(src);
    up_bnc = BNC_W'(bnc); up_data = DATA_W'(dat);
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    up_vld = 1'b0; inj_vld = 1'b0; ej_rdy = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 dn_vld", 32'(dn_vld), 0);
    chk("R1 ej_vld", 32'(ej_vld), 0);
    chk("R1 inj_rdy", 32'(inj_rdy), 1);
  endtask

  task automatic t_pass();
    drive_up(1, 5, 1, 2, 'hAAAA);
    inj_vld = 1'b1; inj_dst = 4'd6; inj_data = 16'hBEEF;
    #1 chk("R3 inj_rdy low", 32'(inj_rdy), 0);
    settle();
    chk("R2 dn_vld", 32'(dn_vld), 1);
    chk("R2 dn_dst", 32'(dn_dst), 5);
    chk("R3 dn_src is ring flit", 32'(dn_src), 1);
    chk("R2 dn_bnc", 32'(dn_bnc), 2);
    chk("R2 dn_data", 32'(dn_data), 'hAAAA);
    idle();
  endtask

  task automatic t_inject();
    inj_vld = 1'b1; inj_dst = 4'd7; inj_data = 16'h1234;
    #1 chk("R4 inj_rdy", 32'(inj_rdy), 1);
    settle();
    chk("R4 dn_vld", 32'(dn_vld), 1);
    chk("R4 dn_dst", 32'(dn_dst), 7);
    chk("R4 dn_src", 32'(dn_src), ME);
    chk("R4 dn_bnc", 32'(dn_bnc), 0);
    chk("R4 dn_data", 32'(dn_data), 'h1234);
    idle();
    settle();
    chk("R4 slot empty after", 32'(dn_vld), 0);
  endtask

  task automatic t_eject();
    drive_up(1, ME, 2, 0, 'h11);
    inj_vld = 1'b1; inj_dst = 4'd6; inj_data = 16'h22;
    #1 chk("R6 inj_rdy on delivery", 32'(inj_rdy), 1);
    settle();
    chk("R5 ej_vld", 32'(ej_vld), 1);
    chk("R5 ej_src", 32'(ej_src), 2);
    chk("R5 ej_data", 32'(ej_data), 'h11);
    chk("R6 dn carries injection", 32'(dn_data), 'h22);
    chk("R6 dn src local", 32'(dn_src), ME);
    idle();
  endtask

  task automatic t_bounce();
    drive_up(1, ME, 4, 0, 'h33);
    settle();
    chk("R5 no forward on delivery", 32'(dn_vld), 0);
    drive_up(1, ME, 4, 0, 'h44);
    ej_rdy = 1'b1;
    #1 chk("R3 inj_rdy low on bounce", 32'(inj_rdy), 0);
    settle();
    chk("R7 bounce dn_vld", 32'(dn_vld), 1);
    chk("R7 bounce dn_bnc", 32'(dn_bnc), 1);
    chk("R7 bounce dn_data", 32'(dn_data), 'h44);
    chk("R8 head after pop", 32'(ej_data), 'h33);
    ej_rdy = 1'b0;
    drive_up(1, ME, 4, 15, 'h55);
    settle();
    chk("R5 delivered once space", 32'(dn_vld), 0);
    drive_up(1, ME, 4, 15, 'h66);
    settle();
    chk("R9 saturated bnc", 32'(dn_bnc), 15);
    chk("R9 saturated data", 32'(dn_data), 'h66);
    idle();
  endtask

  task automatic t_order();
    ej_rdy = 1'b1;
    chk("R8 head first", 32'(ej_data), 'h33);
    settle();
    chk("R8 head second", 32'(ej_data), 'h55);
    settle();
    chk("R8 empty", 32'(ej_vld), 0);
    idle();
    drive_up(1, ME, 4, 1, 'h44);
    settle();
    chk("R5 bounced flit delivered late", 32'(ej_data), 'h44);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 t_reset();
    t_pass();
    t_inject();
    t_eject();
    t_bounce();
    t_order();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule